// File: doc/BRIEF.md
# Network Adapter Board Control and Parity Fault Register Block

This block is the host-facing register set of a shared-memory network adapter. Through a plain 16-bit register port the host holds the board in reset, releases the network interface from loopback, signals attention to the network controller, enables the secondary memory bus, and selects the RAM device size. The same register reports the RAM base address nibble, which comes from board straps, and the live state of the controller interrupt and of the parity fault flag.

The controller interrupt and the parity fault interrupt are each gated by their own enable bit and then merged onto a single host interrupt line. An external parity checker gives a one-cycle strobe with the fault address, the failing byte lane and the fault source. The block keeps the first such fault, together with its details, until the host acknowledges it. Until then any later faults are dropped.

Top module: `adapter_csr`

## Requirements
- R1: After the synchronous reset input, every control bit is 0, every output except `host_rdata` is 0, the status register reads back only the strap nibble, and the fault control and fault address registers read 0.
- R2: Register select 0 is the status register. Bits 14 (online), 12 (controller interrupt enable), 11 (parity interrupt enable), 5 (secondary bus enable) and 4 (256 KB RAM) are written and read back as stored and drive their outputs. Bits 10, 7 and 6 always read 0. Select 3 reads 0.
- R3: Status bit 15 drives `board_reset`. While it is 1, every other writable status bit is held at 0, including bits in the same write. Writing 0 to bit 15 releases reset.
- R4: `chan_attn` goes high for exactly one cycle, in the cycle after the write that changes status bit 13 from 0 to 1. It does not pulse again while the bit stays 1.
- R5: Status bits 3:0 always show `ram_base_strap`, and writes to them have no effect.
- R6: `host_irq` = (`ctrl_irq` AND bit 12) OR (parity flag AND bit 11), taken combinationally.
- R7: A `perr_strobe` while the parity flag is clear sets status bit 9 in the next cycle. It captures the address: bits 19:16 go to fault control (select 1) bits 3:0 and bits 15:0 go to the fault address register (select 2). It also captures `perr_src` into fault control bit 7 and `perr_lane` into bit 6.
- R8: A `perr_strobe` while the parity flag is set leaves the flag and all captured fields unchanged.
- R9: A write to select 1 with bit 8 set clears the parity flag in the next cycle and re-arms capture, and the captured fields stay readable. If a strobe arrives in the same cycle, the acknowledge wins and that strobe is dropped. Bit 8 reads 0, and a write with bit 8 clear changes nothing.
- R10: Status bit 8 shows the `ctrl_irq` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 2 | Register select |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the selected register |
| ram_base_strap | input | 4 | Strapped RAM base address nibble |
| ctrl_irq | input | 1 | Network controller interrupt request |
| perr_strobe | input | 1 | Parity fault strobe from the checker |
| perr_addr | input | FAULT_ADDR_W | Faulting RAM address |
| perr_lane | input | 1 | Failing byte lane |
| perr_src | input | 1 | Fault source indicator |
| board_reset | output | 1 | Board reset drive |
| net_online | output | 1 | Loopback release |
| chan_attn | output | 1 | One-cycle attention pulse to the controller |
| sec_bus_en | output | 1 | Secondary memory bus enable |
| ram_256k | output | 1 | 256 KB RAM device select |
| host_irq | output | 1 | Merged interrupt to the host |

## Verification
The assertions check several properties on every cycle: reset holds every other control output low, attention never lasts past one cycle and only follows a rising control bit, the interrupt is only raised when a source exists, a new fault flag always has a strobe behind it, and captured fields stay frozen until an acknowledge. Other behaviour can only be shown by the bench's scenarios. These include the exact interrupt truth table across all enable, flag and request combinations, the bit placement of every readable field, strap read-through for every nibble, and the outcome when an acknowledge and a strobe arrive in the same cycle.

// File: rtl/adapter_csr_pkg.sv
package adapter_csr_pkg;

    localparam int REG_W      = 16;
    localparam int STRAP_W    = 4;
    localparam int LOW_ADDR_W = 16;

    // status register bit positions
    localparam int SB_BRST   = 15;
    localparam int SB_ONLINE = 14;
    localparam int SB_ATTN   = 13;
    localparam int SB_IEN    = 12;
    localparam int SB_PIEN   = 11;
    localparam int SB_PFLAG  = 9;
    localparam int SB_CFLAG  = 8;
    localparam int SB_SECBUS = 5;
    localparam int SB_RAM256 = 4;

    // fault control register bit positions
    localparam int FB_ACK  = 8;
    localparam int FB_SRC  = 7;
    localparam int FB_LANE = 6;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_FCTRL  = 2'd1,
        SEL_FADDR  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic brst;
        logic online;
        logic attn;
        logic ien;
        logic pien;
        logic secbus;
        logic ram256;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.brst   = w[SB_BRST];
        c.online = w[SB_ONLINE];
        c.attn   = w[SB_ATTN];
        c.ien    = w[SB_IEN];
        c.pien   = w[SB_PIEN];
        c.secbus = w[SB_SECBUS];
        c.ram256 = w[SB_RAM256];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(
        input ctrl_t              c,
        input logic               pflag,
        input logic               cflag,
        input logic [STRAP_W-1:0] strap
    );
        logic [REG_W-1:0] s;
        s             = '0;
        s[SB_BRST]    = c.brst;
        s[SB_ONLINE]  = c.online;
        s[SB_ATTN]    = c.attn;
        s[SB_IEN]     = c.ien;
        s[SB_PIEN]    = c.pien;
        s[SB_PFLAG]   = pflag;
        s[SB_CFLAG]   = cflag;
        s[SB_SECBUS]  = c.secbus;
        s[SB_RAM256]  = c.ram256;
        s[STRAP_W-1:0] = strap;
        return s;
    endfunction

endpackage

// File: rtl/csr_ctrl_reg.sv
module csr_ctrl_reg
    import adapter_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic             attn_pulse
);

    ctrl_t ctrl_d;
    logic  pulse_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = decode_ctrl(wdata);
        end
        // board reset masks every other control bit, held or newly written
        if (ctrl_d.brst) begin
            ctrl_d        = '0;
            ctrl_d.brst   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_d;
            pulse_q <= ctrl_d.attn & ~ctrl_q.attn;
        end
    end

    assign attn_pulse = pulse_q;

endmodule

// File: rtl/csr_fault_latch.sv
module csr_fault_latch #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lane,
    input  logic              src,
    input  logic              ack,
    output logic              flag,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_lane,
    output logic              cap_src
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag     <= 1'b0;
            cap_addr <= '0;
            cap_lane <= 1'b0;
            cap_src  <= 1'b0;
        end else if (ack) begin
            flag <= 1'b0;
        end else if (strobe && !flag) begin
            flag     <= 1'b1;
            cap_addr <= addr;
            cap_lane <= lane;
            cap_src  <= src;
        end
    end

endmodule

// File: rtl/csr_irq_merge.sv
module csr_irq_merge (
    input  logic ctrl_req,
    input  logic ctrl_en,
    input  logic par_flag,
    input  logic par_en,
    output logic irq
);

    assign irq = (ctrl_req & ctrl_en) | (par_flag & par_en);

endmodule

// File: rtl/adapter_csr.sv
module adapter_csr
    import adapter_csr_pkg::*;
#(
    parameter int FAULT_ADDR_W = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_wr,
    input  logic [1:0]              host_sel,
    input  logic [15:0]             host_wdata,
    output logic [15:0]             host_rdata,
    input  logic [3:0]              ram_base_strap,
    input  logic                    ctrl_irq,
    input  logic                    perr_strobe,
    input  logic [FAULT_ADDR_W-1:0] perr_addr,
    input  logic                    perr_lane,
    input  logic                    perr_src,
    output logic                    board_reset,
    output logic                    net_online,
    output logic                    chan_attn,
    output logic                    sec_bus_en,
    output logic                    ram_256k,
    output logic                    host_irq
);

    localparam int HIGH_W = FAULT_ADDR_W - LOW_ADDR_W;

    reg_sel_e                sel;
    ctrl_t                   ctrl;
    logic                    status_wr;
    logic                    fault_ack;
    logic                    fault_flag;
    logic [FAULT_ADDR_W-1:0] cap_addr;
    logic                    cap_lane;
    logic                    cap_src;
    logic [REG_W-1:0]        fctrl_view;

    assign sel       = reg_sel_e'(host_sel);
    assign status_wr = host_wr && (sel == SEL_STATUS);
    assign fault_ack = host_wr && (sel == SEL_FCTRL) && host_wdata[FB_ACK];

    csr_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (status_wr),
        .wdata      (host_wdata),
        .ctrl_q     (ctrl),
        .attn_pulse (chan_attn)
    );

    csr_fault_latch #(.ADDR_W(FAULT_ADDR_W)) u_fault (
        .clk      (clk),
        .rst      (rst),
        .strobe   (perr_strobe),
        .addr     (perr_addr),
        .lane     (perr_lane),
        .src      (perr_src),
        .ack      (fault_ack),
        .flag     (fault_flag),
        .cap_addr (cap_addr),
        .cap_lane (cap_lane),
        .cap_src  (cap_src)
    );

    csr_irq_merge u_irq (
        .ctrl_req (ctrl_irq),
        .ctrl_en  (ctrl.ien),
        .par_flag (fault_flag),
        .par_en   (ctrl.pien),
        .irq      (host_irq)
    );

    always_comb begin
        fctrl_view              = '0;
        fctrl_view[FB_SRC]      = cap_src;
        fctrl_view[FB_LANE]     = cap_lane;
        fctrl_view[HIGH_W-1:0]  = cap_addr[FAULT_ADDR_W-1:LOW_ADDR_W];
    end

    always_comb begin
        case (sel)
            SEL_STATUS: host_rdata = pack_status(ctrl, fault_flag, ctrl_irq, ram_base_strap);
            SEL_FCTRL:  host_rdata = fctrl_view;
            SEL_FADDR:  host_rdata = cap_addr[LOW_ADDR_W-1:0];
            default:    host_rdata = '0;
        endcase
    end

    assign board_reset = ctrl.brst;
    assign net_online  = ctrl.online;
    assign sec_bus_en  = ctrl.secbus;
    assign ram_256k    = ctrl.ram256;

endmodule

// File: rtl/adapter_csr_chk.sv
module adapter_csr_chk #(
    parameter int FAULT_ADDR_W = 20
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    board_reset,
    input logic                    net_online,
    input logic                    sec_bus_en,
    input logic                    ram_256k,
    input logic                    attn_bit,
    input logic                    chan_attn,
    input logic                    host_irq,
    input logic                    ctrl_irq,
    input logic                    perr_strobe,
    input logic                    fault_flag,
    input logic                    fault_ack,
    input logic [FAULT_ADDR_W-1:0] cap_addr
);

    p_brd_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        board_reset |-> (!net_online && !sec_bus_en && !ram_256k && !attn_bit));

    p_attn_once_r4: assert property (@(posedge clk) disable iff (rst)
        chan_attn |=> !chan_attn);

    p_attn_edge_r4: assert property (@(posedge clk) disable iff (rst)
        chan_attn |-> (attn_bit && !$past(attn_bit)));

    p_irq_source_r6: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> (ctrl_irq || fault_flag));

    p_capture_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_flag) |-> $past(perr_strobe));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_flag && !fault_ack) |=> (fault_flag && $stable(cap_addr)));

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
        fault_ack |=> !fault_flag);

endmodule

bind adapter_csr adapter_csr_chk #(.FAULT_ADDR_W(FAULT_ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .board_reset (board_reset),
    .net_online  (net_online),
    .sec_bus_en  (sec_bus_en),
    .ram_256k    (ram_256k),
    .attn_bit    (ctrl.attn),
    .chan_attn   (chan_attn),
    .host_irq    (host_irq),
    .ctrl_irq    (ctrl_irq),
    .perr_strobe (perr_strobe),
    .fault_flag  (fault_flag),
    .fault_ack   (fault_ack),
    .cap_addr    (cap_addr)
);

// File: tb/adapter_csr_test.sv
module adapter_csr_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic [3:0]  ram_base_strap = 4'hA;
    logic        ctrl_irq = 1'b0;
    logic        perr_strobe = 1'b0;
    logic [19:0] perr_addr = 20'h0;
    logic        perr_lane = 1'b0;
    logic        perr_src = 1'b0;
    logic        board_reset, net_online, chan_attn, sec_bus_en, ram_256k, host_irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] rv;

    adapter_csr uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ram_base_strap(ram_base_strap), .ctrl_irq(ctrl_irq),
        .perr_strobe(perr_strobe), .perr_addr(perr_addr),
        .perr_lane(perr_lane), .perr_src(perr_src),
        .board_reset(board_reset), .net_online(net_online),
        .chan_attn(chan_attn), .sec_bus_en(sec_bus_en),
        .ram_256k(ram_256k), .host_irq(host_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = data;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = 16'h0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] data);
        host_sel = sel;
        #1;
        data = host_rdata;
    endtask

    task automatic perr(input logic [19:0] a, input logic lane, input logic src);
        @(negedge clk);
        perr_strobe = 1'b1; perr_addr = a; perr_lane = lane; perr_src = src;
        @(negedge clk);
        perr_strobe = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, rv); check("R1 status", rv, 16'h000A);
        rd(2'd1, rv); check("R1 fctrl", rv, 16'h0000);
        rd(2'd2, rv); check("R1 faddr", rv, 16'h0000);
        check("R1 outputs", {10'd0, board_reset, net_online, chan_attn, sec_bus_en, ram_256k, host_irq}, 16'h0);

        // R5 strap read-through, every nibble
        for (int s = 0; s < 16; s++) begin
            ram_base_strap = s[3:0];
            rd(2'd0, rv); check("R5 strap", rv, {12'h0, s[3:0]});
        end
        ram_base_strap = 4'h5;
        wr(2'd0, 16'h000F);
        rd(2'd0, rv); check("R5 write ignored", rv, 16'h0005);

        // R2 sweep of writable bits with junk bits set
        for (int k = 0; k < 32; k++) begin
            logic [15:0] w, e;
            e = '0;
            e[14] = k[0]; e[12] = k[1]; e[11] = k[2]; e[5] = k[3]; e[4] = k[4];
            w = e | 16'h04CF;
            wr(2'd0, w);
            rd(2'd0, rv); check("R2 readback", rv, e | 16'h0005);
            check("R2 outputs", {13'd0, net_online, sec_bus_en, ram_256k}, {13'd0, e[14], e[5], e[4]});
        end
        rd(2'd3, rv); check("R2 select 3", rv, 16'h0000);

        // R3 board reset masks others
        wr(2'd0, 16'hF830);
        rd(2'd0, rv); check("R3 reset masks same write", rv, 16'h8005);
        check("R3 board_reset high", {15'd0, board_reset}, 16'h1);
        check("R3 no attn during reset", {15'd0, chan_attn}, 16'h0);
        wr(2'd0, 16'hF830);
        rd(2'd0, rv); check("R3 held reset", rv, 16'h8005);
        wr(2'd0, 16'h0000);
        rd(2'd0, rv); check("R3 release", rv, 16'h0005);
        check("R3 board_reset low", {15'd0, board_reset}, 16'h0);

        // R4 attention pulse
        wr(2'd0, 16'h2000);
        check("R4 pulse high", {15'd0, chan_attn}, 16'h1);
        @(negedge clk);
        check("R4 pulse one cycle", {15'd0, chan_attn}, 16'h0);
        wr(2'd0, 16'h2000);
        check("R4 no pulse when held", {15'd0, chan_attn}, 16'h0);
        wr(2'd0, 16'h0000);
        check("R4 no pulse on clear", {15'd0, chan_attn}, 16'h0);
        wr(2'd0, 16'h2000);
        check("R4 pulse again", {15'd0, chan_attn}, 16'h1);
        wr(2'd0, 16'h0000);

        // R10 controller interrupt flag
        ctrl_irq = 1'b1;
        rd(2'd0, rv); check("R10 flag set", rv, 16'h0105);
        ctrl_irq = 1'b0;
        rd(2'd0, rv); check("R10 flag clear", rv, 16'h0005);

        // R7 capture
        perr(20'hB1234, 1'b1, 1'b0);
        rd(2'd0, rv); check("R7 pflag", rv, 16'h0205);
        rd(2'd1, rv); check("R7 fctrl", rv, 16'h004B);
        rd(2'd2, rv); check("R7 faddr", rv, 16'h1234);

        // R8 second fault ignored
        perr(20'h5FFFF, 1'b0, 1'b1);
        rd(2'd1, rv); check("R8 fctrl held", rv, 16'h004B);
        rd(2'd2, rv); check("R8 faddr held", rv, 16'h1234);

        // R9 acknowledge
        wr(2'd1, 16'h00FF);
        rd(2'd0, rv); check("R9 no ack without bit8", rv, 16'h0205);
        wr(2'd1, 16'h0100);
        rd(2'd0, rv); check("R9 ack clears", rv, 16'h0005);
        rd(2'd1, rv); check("R9 fields retained, ack reads 0", rv, 16'h004B);
        perr(20'h300FF, 1'b0, 1'b1);
        rd(2'd1, rv); check("R9 rearmed fctrl", rv, 16'h0083);
        rd(2'd2, rv); check("R9 rearmed faddr", rv, 16'h00FF);
        // acknowledge and strobe in the same cycle: acknowledge wins
        @(negedge clk);
        host_wr = 1'b1; host_sel = 2'd1; host_wdata = 16'h0100;
        perr_strobe = 1'b1; perr_addr = 20'h7AAAA; perr_lane = 1'b1; perr_src = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; perr_strobe = 1'b0;
        rd(2'd0, rv); check("R9 ack beats strobe", rv, 16'h0005);
        rd(2'd2, rv); check("R9 dropped strobe", rv, 16'h00FF);

        // R6 interrupt truth table
        for (int m = 0; m < 16; m++) begin
            logic ie, pie, pf, ci;
            {ie, pie, pf, ci} = m[3:0];
            if (pf) perr(20'h00001, 1'b0, 1'b0);
            else    wr(2'd1, 16'h0100);
            wr(2'd0, {3'b000, ie, pie, 11'h0});
            ctrl_irq = ci;
            #1;
            check("R6 irq", {15'd0, host_irq}, {15'd0, (ci & ie) | (pf & pie)});
            ctrl_irq = 1'b0;
        end

        // R3 reset clears enables, so interrupt drops
        wr(2'd0, 16'h1800);
        ctrl_irq = 1'b1;
        wr(2'd0, 16'h8000);
        check("R3 reset drops irq", {15'd0, host_irq}, 16'h0);
        ctrl_irq = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule